// File: doc/BRIEF.md
# Page-Mode Flash Read Controller

This block sits on the host side of an asynchronous parallel NOR-style memory. It turns read requests into chip-enable, output-enable and address activity on the memory pins. A request carries a word address and a burst length of one to eight words. The block presents each address, waits a programmable number of clock cycles, captures the data bus and returns the word with a one-cycle valid strobe.

The memory is organised in pages of eight 16-bit words that share all address bits above the lowest three. The first word fetched from a page needs the long random-access delay. Further words from the same page need only the short page delay, as long as chip-enable has stayed low and the upper address bits are unchanged. A burst that runs past the end of a page continues on the next page, and the word after the boundary pays the long delay again.

After a request ends, chip-enable stays low for a fixed hold window with output-enable high, so the data bus is released. A request arriving inside that window for the same page gets the short delay on its first word. When the window runs out, chip-enable rises and the memory drops into standby.

Top module: `pgrd_read_ctrl`

## Requirements
- R1: During and right after reset, mem_ce_n and mem_oe_n are 1, rd_valid is 0 and req_ready is 1.
- R2: When a request is accepted with chip-enable high, its first word is captured at the clock edge that lies cfg_acc_cyc edges after the accepting edge. rd_valid is 1 in the cycle that follows.
- R3: Each later word of a request that stays on the same page is captured cfg_page_cyc edges after the previous capture.
- R4: req_len encodes the burst as words minus one (0 means 1 word, 7 means 8). Word k of a request is read from req_addr+k. rd_addr carries that address and rd_data carries that word's data.
- R5: A page is the set of addresses sharing bits [ADDR_W-1:3]. When a burst steps from offset 7 to the next page, the next word uses the full access delay.
- R6: mem_oe_n is 0 only while a word is being fetched. While chip-enable is held between requests, mem_ce_n is 0 and mem_oe_n is 1.
- R7: After the last capture of a request, mem_ce_n stays 0 for HOLD_CYC cycles (default 4) and then goes to 1. A request accepted inside that window whose upper address bits match the last word's address uses cfg_page_cyc for its first word. This holds for any low-bit order.
- R8: A request accepted inside the hold window for a different page uses cfg_access_cyc for its first word.
- R9: A request accepted on the same edge at which the hold window would expire counts as inside the window. Chip-enable does not rise.
- R10: Each word produces exactly one cycle of rd_valid, and the data is taken from the bus at the last cycle of that word's delay window.
- R11: Both delays are sampled when the request is accepted. Changing cfg_acc_cyc or cfg_page_cyc during a request does not change its timing.
- R12: A configured delay of 0 is treated as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | ADDR_W | Word address of the first word |
| req_len | input | 3 | Burst length minus one |
| cfg_acc_cyc | input | DLY_W | Random-access delay in cycles |
| cfg_page_cyc | input | DLY_W | Page-access delay in cycles |
| mem_ce_n | output | 1 | Memory chip-enable, active low |
| mem_oe_n | output | 1 | Memory output-enable, active low |
| mem_addr | output | ADDR_W | Memory word address |
| mem_dq | input | DATA_W | Memory data bus |
| rd_valid | output | 1 | Returned word valid, one cycle per word |
| rd_addr | output | ADDR_W | Address of the returned word |
| rd_data | output | DATA_W | Returned word |

## Verification
Two events can land on the same clock edge: the end of the hold window and the acceptance of a new request. The bench times a request so that it is accepted exactly on the expiry edge. It then checks three things: chip-enable never rises, the first word arrives after the page delay and not the access delay, and the data returned is the data the memory model actually drove. The behavioural memory model returns correct data only once the address has been stable for the delay the memory needs, so a controller that shortens any window produces wrong data as well as wrong timing.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;

    // Page geometry is fixed by the memory: eight words per page.
    localparam int PG_BITS    = 3;
    localparam int PG_WORDS   = 1 << PG_BITS;

    localparam int DEF_ADDR_W = 20;
    localparam int DEF_DATA_W = 16;
    localparam int DEF_DLY_W  = 8;
    localparam int DEF_HOLD   = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_HOLD   = 2'd2
    } rd_state_e;

    typedef logic [PG_BITS-1:0] pg_off_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
    } pin_ctl_t;

    // True when the offset is the final word of its page.
    function automatic logic off_at_end(input pg_off_t off);
        return &off;
    endfunction

    // Pin levels that belong to each controller state.
    function automatic pin_ctl_t pins_for(input rd_state_e s);
        pin_ctl_t p;
        case (s)
            ST_ACCESS: p = '{ce_n: 1'b0, oe_n: 1'b0};
            ST_HOLD:   p = '{ce_n: 1'b0, oe_n: 1'b1};
            default:   p = '{ce_n: 1'b1, oe_n: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pgrd_timer.sv
module pgrd_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    // High during the final cycle of a loaded window.
    assign expire = (cnt_q == W'(1));
endmodule

// File: rtl/pgrd_addr_seq.sv
module pgrd_addr_seq
    import pgrd_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [PG_BITS-1:0] start_len,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              final_word,
    output logic              next_new_page
);
    logic [PG_BITS-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            left_q   <= '0;
        end else if (start) begin
            cur_addr <= start_addr;
            left_q   <= start_len;
        end else if (step) begin
            cur_addr <= cur_addr + ADDR_W'(1);
            left_q   <= left_q - PG_BITS'(1);
        end
    end

    assign final_word    = (left_q == '0);
    assign next_new_page = off_at_end(cur_addr[PG_BITS-1:0]);
endmodule

// File: rtl/pgrd_read_ctrl.sv
module pgrd_read_ctrl
    import pgrd_pkg::*;
#(
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int DATA_W   = DEF_DATA_W,
    parameter int DLY_W    = DEF_DLY_W,
    parameter int HOLD_CYC = DEF_HOLD
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [PG_BITS-1:0]  req_len,
    input  logic [DLY_W-1:0]    cfg_acc_cyc,
    input  logic [DLY_W-1:0]    cfg_page_cyc,
    output logic                mem_ce_n,
    output logic                mem_oe_n,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [DATA_W-1:0]   mem_dq,
    output logic                rd_valid,
    output logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data
);
    localparam int TAG_LO = PG_BITS;
    localparam int HOLD_W = (HOLD_CYC > 0) ? $clog2(HOLD_CYC + 1) : 1;

    typedef struct packed {
        logic [DLY_W-1:0] acc;
        logic [DLY_W-1:0] pg;
    } dly_pair_t;

    function automatic logic [DLY_W-1:0] at_least_one(input logic [DLY_W-1:0] v);
        return (v == '0) ? DLY_W'(1) : v;
    endfunction

    rd_state_e         st_q, st_d;
    dly_pair_t         dly_q, dly_in;
    pin_ctl_t          pins_d;
    logic              accept, open_hit, word_done, step;
    logic              win_last, final_word, next_new, hold_load, hold_expire;
    logic              tmr_load;
    logic [DLY_W-1:0]  tmr_val;
    logic [ADDR_W-1:0] cur_addr;

    assign req_ready = (st_q != ST_ACCESS);
    assign accept    = req_valid && req_ready;
    assign open_hit  = (st_q == ST_HOLD) &&
                       (req_addr[ADDR_W-1:TAG_LO] == cur_addr[ADDR_W-1:TAG_LO]);
    assign dly_in    = '{acc: at_least_one(cfg_acc_cyc), pg: at_least_one(cfg_page_cyc)};
    assign word_done = (st_q == ST_ACCESS) && win_last;
    assign step      = word_done && !final_word;
    assign hold_load = word_done && final_word;

    // Delay for the next window: fresh config on accept, latched values on later words.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = dly_q.pg;
        if (accept) begin
            tmr_load = 1'b1;
            tmr_val  = open_hit ? dly_in.pg : dly_in.acc;
        end else if (step) begin
            tmr_load = 1'b1;
            tmr_val  = next_new ? dly_q.acc : dly_q.pg;
        end
    end

    pgrd_timer #(.W(DLY_W)) i_win_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (win_last)
    );

    pgrd_addr_seq #(.ADDR_W(ADDR_W)) i_seq (
        .clk           (clk),
        .rst           (rst),
        .start         (accept),
        .start_addr    (req_addr),
        .start_len     (req_len),
        .step          (step),
        .cur_addr      (cur_addr),
        .final_word    (final_word),
        .next_new_page (next_new)
    );

    generate
        if (HOLD_CYC > 0) begin : g_hold
            pgrd_timer #(.W(HOLD_W)) i_hold_tmr (
                .clk      (clk),
                .rst      (rst),
                .load     (hold_load),
                .load_val (HOLD_W'(HOLD_CYC)),
                .expire   (hold_expire)
            );
        end else begin : g_no_hold
            assign hold_expire = 1'b1;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: begin
                if (accept) st_d = ST_ACCESS;
            end
            ST_ACCESS: begin
                if (hold_load) st_d = (HOLD_CYC > 0) ? ST_HOLD : ST_IDLE;
            end
            ST_HOLD: begin
                if (accept)           st_d = ST_ACCESS;
                else if (hold_expire) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign pins_d   = pins_for(st_d);
    assign mem_addr = cur_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            dly_q    <= '{acc: DLY_W'(1), pg: DLY_W'(1)};
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
            rd_valid <= 1'b0;
            rd_addr  <= '0;
            rd_data  <= '0;
        end else begin
            st_q     <= st_d;
            mem_ce_n <= pins_d.ce_n;
            mem_oe_n <= pins_d.oe_n;
            rd_valid <= word_done;
            if (accept) dly_q <= dly_in;
            if (word_done) begin
                rd_addr <= cur_addr;
                rd_data <= mem_dq;
            end
        end
    end
endmodule

// File: rtl/pgrd_chk.sv
module pgrd_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rd_valid
);
    AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
        mem_ce_n |-> mem_oe_n); // R6

    AST_ADDR_HELD_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n && $past(!mem_oe_n) && !rd_valid) |-> $stable(mem_addr)); // R3

    AST_RELEASE_FROM_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_ce_n) |-> $past(mem_oe_n)); // R7

    AST_VALID_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!mem_oe_n)); // R10

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(mem_ce_n) |-> !rd_valid); // R10

    AST_READY_OFF_BUS: assert property (@(posedge clk) disable iff (rst)
        mem_oe_n |-> req_ready); // R1
endmodule

bind pgrd_read_ctrl pgrd_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_addr  (mem_addr),
    .rd_valid  (rd_valid)
);

// File: tb/test_pgrd_read_ctrl.sv
module test_pgrd_read_ctrl;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int DLW = 8;
    localparam int HOLD = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [2:0]    req_len = '0;
    logic [DLW-1:0] cfg_acc_cyc = 8'd5;
    logic [DLW-1:0] cfg_page_cyc = 8'd2;
    logic          mem_ce_n, mem_oe_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq;
    logic          rd_valid;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;

    int  cyc = 0;
    int  vcount = 0;
    int  checks = 0;
    int  errors = 0;
    int  e_acc = 5;
    int  e_pg = 2;
    bit  done = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) if (rd_valid) vcount <= vcount + 1;

    pgrd_read_ctrl #(.ADDR_W(AW), .DATA_W(DW), .DLY_W(DLW), .HOLD_CYC(HOLD)) i_pgrd_read_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .cfg_acc_cyc(cfg_acc_cyc),
        .cfg_page_cyc(cfg_page_cyc), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq(mem_dq), .rd_valid(rd_valid),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {a[3:0], a[15:4]} ^ {12'h000, a[19:16]} ^ 16'hA5C3;
    endfunction

    // Behavioural memory: data is correct only after the address has been stable long enough.
    logic [AW-1:0] m_last = '0;
    int  m_age = 0;
    int  m_need = 1;
    bit  m_have = 0;
    always @(negedge clk) begin
        if (mem_ce_n) begin
            m_have <= 0;
            m_age  <= 0;
        end else if (!m_have || mem_addr != m_last) begin
            m_need <= (!m_have || mem_addr[AW-1:3] != m_last[AW-1:3] || m_age < m_need) ? e_acc : e_pg;
            m_age  <= 1;
            m_last <= mem_addr;
            m_have <= 1;
        end else if (m_age < 1000) begin
            m_age <= m_age + 1;
        end
    end
    assign mem_dq = (!mem_ce_n && !mem_oe_n && m_have && m_age >= m_need) ? pat(mem_addr) : 16'hDEAD;

    task automatic check(input bit ok, input string r, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", r, act, exp, cyc);
        end
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic go_standby();
        int guard = 0;
        while (!mem_ce_n && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    task automatic set_cfg(input int a, input int p);
        cfg_acc_cyc  = DLW'(a);
        cfg_page_cyc = DLW'(p);
        e_acc = (a == 0) ? 1 : a;
        e_pg  = (p == 0) ? 1 : p;
    endtask

    // Issue at the current negedge; returns the capture edge of the last word.
    task automatic do_read(input logic [AW-1:0] a, input logic [2:0] len, input bit open_pg, output int ec);
        int t;
        int d;
        int v0;
        logic [AW-1:0] ai;
        check(req_ready == 1'b1, "R7 ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = a;
        req_len   = len;
        v0 = vcount;
        t  = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
        check(!mem_ce_n && !mem_oe_n, "R6 pins low while fetching", {mem_ce_n, mem_oe_n}, 0);
        ai = a;
        for (int i = 0; i <= int'(len); i++) begin
            string tag;
            if (i == 0) begin
                d   = open_pg ? e_pg : e_acc;
                tag = open_pg ? "R7 first word on open page" : "R2 first word access delay";
            end else if (ai[2:0] == 3'd0) begin
                d   = e_acc;
                tag = "R5 word after page boundary";
            end else begin
                d   = e_pg;
                tag = "R3 page delay";
            end
            if (d > 1) begin
                wait_to(t + d - 1);
                check(rd_valid == 1'b0, tag, int'(rd_valid), 0);
            end
            t = t + d;
            wait_to(t);
            check(rd_valid == 1'b1, tag, int'(rd_valid), 1);
            check(rd_addr == ai, "R4 returned address", int'(rd_addr), int'(ai));
            check(rd_data == pat(ai), "R4 returned data", int'(rd_data), int'(pat(ai)));
            ai = ai + 1;
        end
        @(negedge clk);
        check(vcount - v0 == int'(len) + 1, "R10 one valid cycle per word", vcount - v0, int'(len) + 1);
        ec = t;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(mem_ce_n && mem_oe_n, "R1 pins in reset", {mem_ce_n, mem_oe_n}, 3);
        check(!rd_valid && req_ready, "R1 valid/ready in reset", {rd_valid, req_ready}, 1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(mem_ce_n && mem_oe_n && !rd_valid && req_ready, "R1 state after reset",
              {mem_ce_n, mem_oe_n, rd_valid, req_ready}, 4'b1101);
    endtask

    task automatic t_full_page();
        int ec;
        set_cfg(5, 2);
        go_standby();
        do_read(20'h00100, 3'd7, 0, ec);
    endtask

    task automatic t_single();
        int ec;
        go_standby();
        do_read(20'h00345, 3'd0, 0, ec);
    endtask

    task automatic t_cross_and_hold();
        int ec;
        go_standby();
        do_read(20'h00236, 3'd4, 0, ec);
        do_read(20'h0023D, 3'd1, 1, ec);
        do_read(20'h00239, 3'd0, 1, ec);
        do_read(20'h0023F, 3'd0, 1, ec);
        wait_to(ec + HOLD - 1);
        check(!mem_ce_n && mem_oe_n, "R6 hold keeps ce low, oe high", {mem_ce_n, mem_oe_n}, 1);
        wait_to(ec + HOLD);
        check(mem_ce_n == 1'b1, "R7 release after hold window", int'(mem_ce_n), 1);
    endtask

    task automatic t_hold_miss();
        int ec;
        go_standby();
        do_read(20'h00400, 3'd0, 0, ec);
        do_read(20'h00408, 3'd0, 0, ec);
        check(1'b1, "R8 other page in hold used access delay", 0, 0);
    endtask

    task automatic t_expiry_race();
        int ec;
        go_standby();
        do_read(20'h00500, 3'd1, 0, ec);
        wait_to(ec + HOLD - 1);
        check(mem_ce_n == 1'b0, "R9 ce low before expiry edge", int'(mem_ce_n), 0);
        do_read(20'h00503, 3'd0, 1, ec);
        check(mem_ce_n == 1'b0, "R9 ce never released", int'(mem_ce_n), 0);
        go_standby();
        do_read(20'h00504, 3'd0, 0, ec);
    endtask

    task automatic t_cfg_change();
        int ec;
        set_cfg(3, 2);
        go_standby();
        fork
            do_read(20'h00610, 3'd3, 0, ec);
            begin
                @(negedge clk);
                @(negedge clk);
                cfg_acc_cyc  = 8'd9;
                cfg_page_cyc = 8'd9;
            end
        join
        check(1'b1, "R11 timing kept latched delays", 0, 0);
    endtask

    task automatic t_zero_delay();
        int ec;
        set_cfg(0, 0);
        go_standby();
        do_read(20'h00700, 3'd7, 0, ec);
        check(1'b1, "R12 zero delay ran as one cycle", 0, 0);
        set_cfg(5, 2);
    endtask

    initial begin
        t_reset();
        t_full_page();
        t_single();
        t_cross_and_hold();
        t_hold_miss();
        t_expiry_race();
        t_cfg_change();
        t_zero_delay();
        repeat (5) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule